// File: doc/BRIEF.md
# Fall-Through FIFO Stack

This block is a small first-in first-out store that keeps no read or write pointers. It is a column of word locations, each with its own occupancy bit. A word enters at the top location and then drops one location per clock cycle on its own, stopping only when the location beneath it is held. Words therefore gather at the bottom in arrival order. The output side sees the word at the bottom location and removes it with a take strobe.

The write side gets a single status, top-empty, and may write only while it is high. The read side gets bottom-valid and the bottom word. Because a freed bottom location lets every word above it move down in the same cycle, a full column opens its top location one cycle after a take. Reset clears only the occupancy bits. The stored words stay in their registers and still show at the bottom data port.

Top module: `fts_stack`

## Requirements
- R1: With default parameters the stack holds 14 words of 4 bits each. Words leave the bottom in exactly the order in which they were accepted at the top.
- R2: A write is accepted on a rising clock edge only when wr_en is high and top_empty is high. top_empty is low in the cycle after an accepted write, so a write held in the next cycle is refused.
- R3: An occupied location moves its word down one place on each edge if the location below is empty or is being vacated on that edge. On an empty stack, a word accepted on edge k makes bot_valid high after edge k+13 and not before.
- R4: When all 14 locations are occupied and no take happens, top_empty stays low and writes leave the stored contents unchanged.
- R5: While bot_valid is high and take is low, bot_valid and bot_data hold their values. Take with bot_valid high removes the bottom word on the next edge. Take with bot_valid low has no effect.
- R6: An active-low reset clears every occupancy bit, giving top_empty high and bot_valid low. It leaves the stored words unchanged, so bot_data still shows the word last held at the bottom.
- R7: When the stack is full, a take frees the top location on the same edge. top_empty is high after that edge, and the next word is already at the bottom.
- R8: The number of occupied locations rises by one for each accepted write and falls by one for each accepted take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of occupancy state |
| wr_en | input | 1 | Write request into the top location |
| wr_data | input | WIDTH | Word to write |
| top_empty | output | 1 | High when the top location can accept a word |
| bot_valid | output | 1 | High when the bottom location holds a word |
| bot_data | output | WIDTH | Word at the bottom location |
| take | input | 1 | Removes the bottom word when bot_valid is high |

## Verification
The hardest state to reach from the ports is a completely full column in which a single take makes every word shift at once, through the full-length combinational ripple. Writes are accepted at most every second cycle, so the bench fills the stack with a directed sequence that writes whenever top_empty is seen high and never takes. It then lets the column settle, holds writes against the full stack, and issues one take before checking the top status and the next bottom word. Random write and take mixes with a fixed seed then check ordering against a queue, including takes on an empty bottom and writes while the top is busy.

// File: rtl/fts_pkg.sv
package fts_pkg;

   localparam int FTS_DEPTH_DEF = 14;
   localparam int FTS_WIDTH_DEF = 4;

   // per-location move controls produced by the flow logic
   typedef struct packed {
      logic fill;   // a word arrives into this location on this edge
      logic drain;  // the word here leaves on this edge
   } slot_ctl_t;

endpackage

// File: rtl/fts_slot.sv
module fts_slot
   import fts_pkg::*;
#(
   parameter int WIDTH = FTS_WIDTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  slot_ctl_t        ctl,
   input  logic [WIDTH-1:0] din,
   output logic             occ,
   output logic [WIDTH-1:0] dout
);

   // occupancy is the only state touched by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= 1'b0;
      end else if (ctl.fill) begin
         occ <= 1'b1;
      end else if (ctl.drain) begin
         occ <= 1'b0;
      end
   end

   // storage keeps its word across reset
   always_ff @(posedge clk) begin
      if (ctl.fill) begin
         dout <= din;
      end
   end

   // R3: a word may only arrive into a free or freeing location
   a_r3_fill_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.fill |-> (!occ || ctl.drain));

   // R3: a drained location is empty afterwards unless refilled
   a_r3_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.drain && !ctl.fill) |=> !occ);

endmodule

// File: rtl/fts_flow.sv
module fts_flow
   import fts_pkg::*;
#(
   parameter int DEPTH = FTS_DEPTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] occ,
   input  logic             wr_req,
   input  logic             take,
   output slot_ctl_t        ctl [DEPTH],
   output logic             wr_acc,
   output logic             take_acc
);

   localparam int LAST = DEPTH - 1;

   logic [DEPTH-1:0] drain;
   logic [DEPTH-1:0] fill;

   // bottom leaves only on request; every other location leaves when the
   // one below is free now or is freed on this same edge
   assign drain[LAST] = occ[LAST] & take;

   for (genvar i = 0; i < LAST; i++) begin : g_ripple
      assign drain[i] = occ[i] & (~occ[i+1] | drain[i+1]);
   end

   assign fill[0] = wr_req & ~occ[0];

   for (genvar i = 1; i < DEPTH; i++) begin : g_fill
      assign fill[i] = drain[i-1];
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ctl
      assign ctl[i].fill  = fill[i];
      assign ctl[i].drain = drain[i];
   end

   assign wr_acc   = fill[0];
   assign take_acc = drain[LAST];

   // R4: a full column with no take never accepts a write
   a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (&occ && !take) |-> !wr_acc);

   // R5: a take on an empty bottom removes nothing
   a_r5_take_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (!occ[LAST]) |-> !take_acc);

endmodule

// File: rtl/fts_stack.sv
module fts_stack
   import fts_pkg::*;
#(
   parameter int DEPTH = FTS_DEPTH_DEF,
   parameter int WIDTH = FTS_WIDTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             top_empty,
   output logic             bot_valid,
   output logic [WIDTH-1:0] bot_data,
   input  logic             take
);

   localparam int LAST = DEPTH - 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fts_stack: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("fts_stack: WIDTH must be at least 1");
   end

   logic [DEPTH-1:0] occ;
   slot_ctl_t        ctl     [DEPTH];
   logic [WIDTH-1:0] slot_in [DEPTH];
   logic [WIDTH-1:0] slot_q  [DEPTH];
   logic             wr_acc;
   logic             take_acc;

   fts_flow #(.DEPTH(DEPTH)) u_flow (
      .clk      (clk),
      .rst_n    (rst_n),
      .occ      (occ),
      .wr_req   (wr_en),
      .take     (take),
      .ctl      (ctl),
      .wr_acc   (wr_acc),
      .take_acc (take_acc)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
         assign slot_in[i] = wr_data;
      end else begin : g_body
         assign slot_in[i] = slot_q[i-1];
      end

      fts_slot #(.WIDTH(WIDTH)) u_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .ctl  (ctl[i]),
         .din  (slot_in[i]),
         .occ  (occ[i]),
         .dout (slot_q[i])
      );
   end

   assign top_empty = ~occ[0];
   assign bot_valid = occ[LAST];
   assign bot_data  = slot_q[LAST];

   // R2: an accepted write makes the top busy on the next cycle
   a_r2_top_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && top_empty) |=> !top_empty);

   // R5: the bottom word is held until taken
   a_r5_bottom_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bot_valid && !take) |=> (bot_valid && $stable(bot_data)));

   // R8: occupancy is conserved across writes and takes
   a_r8_count_conserved: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($countones(occ) ==
         $countones($past(occ)) + int'($past(wr_acc)) - int'($past(take_acc))));

   // R1: a word moving down carries its value unchanged
   for (genvar i = 0; i < LAST; i++) begin : g_chk_move
      a_r1_word_carried: assert property (@(posedge clk) disable iff (!rst_n)
         ctl[i].drain |=> (slot_q[i+1] == $past(slot_q[i])));
   end

endmodule

// File: tb/fts_stack_bench.sv
module fts_stack_bench;

   localparam int DEPTH = 14;
   localparam int WIDTH = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             take = 1'b0;
   logic             top_empty;
   logic             bot_valid;
   logic [WIDTH-1:0] bot_data;

   int errors = 0;
   int checks = 0;
   bit done   = 0;
   logic [WIDTH-1:0] q [$];

   always #2 clk = ~clk;  // 250 MHz

   fts_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fts_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .top_empty(top_empty),
      .bot_valid(bot_valid),
      .bot_data (bot_data),
      .take     (take)
   );

   // edges from an accepted write on an empty stack until bot_valid is seen
   function automatic int exp_latency();
      return DEPTH;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drain_all(input string req);
      int guard = 0;
      while (q.size() > 0 && guard < 2000) begin
         @(negedge clk);
         take = 1'b0;
         wr_en = 1'b0;
         if (bot_valid) begin
            chk(req, 32'(bot_data), 32'(q[0]));
            void'(q.pop_front());
            take = 1'b1;
         end
         guard++;
      end
      @(negedge clk);
      take = 1'b0;
      chk({req, " drained"}, 32'(q.size()), 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int n;
      int acc;
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_0403);

      repeat (3) @(negedge clk);
      chk("R6 reset top_empty", 32'(top_empty), 32'd1);
      chk("R6 reset bot_valid", 32'(bot_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: take on empty bottom does nothing
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      chk("R5 take on empty", 32'(bot_valid), 32'd0);
      chk("R5 take on empty top", 32'(top_empty), 32'd1);

      // R3 latency and R2 top busy after write
      wr_en = 1'b1; wr_data = 4'hA;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 4'h5;   // back-to-back, must be refused
      chk("R2 top busy after write", 32'(top_empty), 32'd0);
      q.push_back(4'hA);
      n = 1;
      @(negedge clk);
      wr_en = 1'b0;
      n++;
      chk("R2 top free after move", 32'(top_empty), 32'd1);
      while (!bot_valid && n < 40) begin
         if (n == exp_latency() - 1) chk("R3 not early", 32'(bot_valid), 32'd0);
         @(negedge clk);
         n++;
      end
      chk("R3 fall-through latency", 32'(n), 32'(exp_latency()));
      chk("R1 first word at bottom", 32'(bot_data), 32'hA);
      drain_all("R2 refused word absent");
      repeat (20) @(negedge clk);
      chk("R2 second write refused", 32'(bot_valid), 32'd0);

      // R4/R7: fill completely
      acc = 0;
      n = 0;
      while (acc < DEPTH && n < 400) begin
         @(negedge clk);
         wr_en = 1'b0;
         if (top_empty) begin
            wr_en = 1'b1;
            wr_data = 4'(acc + 3);
            q.push_back(4'(acc + 3));
            acc++;
         end
         n++;
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (20) @(negedge clk);
      chk("R4 full top_empty low", 32'(top_empty), 32'd0);
      chk("R4 full bot_valid", 32'(bot_valid), 32'd1);
      wr_en = 1'b1; wr_data = 4'hF;
      repeat (6) begin
         @(negedge clk);
         chk("R4 write on full refused", 32'(top_empty), 32'd0);
      end
      wr_en = 1'b0;
      chk("R1 oldest at bottom", 32'(bot_data), 32'(q[0]));
      void'(q.pop_front());
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      chk("R7 top freed by take", 32'(top_empty), 32'd1);
      chk("R7 next word at bottom", 32'(bot_valid), 32'd1);
      chk("R7 next word value", 32'(bot_data), 32'(q[0]));
      drain_all("R4 contents after full writes");
      repeat (20) @(negedge clk);
      chk("R4 no extra word", 32'(bot_valid), 32'd0);

      // R6: reset keeps data
      wr_en = 1'b1; wr_data = 4'h9;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (20) @(negedge clk);
      chk("R6 word before reset", 32'(bot_data), 32'h9);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R6 reset clears bot_valid", 32'(bot_valid), 32'd0);
      chk("R6 reset clears top", 32'(top_empty), 32'd1);
      chk("R6 data retained", 32'(bot_data), 32'h9);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R8: random mix
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         wr_en = 1'b0;
         take = 1'b0;
         if (($urandom % 4) != 0) begin
            wr_en = 1'b1;
            wr_data = 4'($urandom);
            if (top_empty) q.push_back(wr_data);
         end
         if (($urandom % 3) == 0) begin
            take = 1'b1;
            if (bot_valid) begin
               chk("R1 random order", 32'(bot_data), 32'(q[0]));
               void'(q.pop_front());
            end
         end
         if (q.size() > DEPTH) chk("R8 occupancy bound", 32'(q.size()), 32'(DEPTH));
      end
      @(negedge clk);
      wr_en = 1'b0;
      take = 1'b0;
      drain_all("R8 random drain");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule